// File: doc/BRIEF.md
# Sequential Circular-Buffer FIR Filter

This block filters a stream of 16-bit signed audio samples with a finite impulse response. It holds one multiplier and one accumulator and reuses them once per tap. Each arriving sample goes into a circular history memory at a write pointer that wraps at the active tap count, so no stored sample is ever moved. The block then walks the history forward from the oldest sample. It walks the coefficient table backward from its last entry at the same time. It accumulates the products, rounds and saturates the sum to 16 bits, and emits one output sample.

The host writes the coefficients through a simple address/data write port while the filter is idle. It selects the active tap count at run time, up to a synthesis maximum, and offers samples with a one-cycle strobe. While a computation is in progress the block reports busy. A sample offered during that time is dropped and flagged.

Top module: `seq_fir`

## Requirements
- R1: Each accepted sample produces exactly one output. `out_valid` is high for a single cycle, N+2 clock edges after the edge that accepted the sample, where N is the active tap count.
- R2: The output equals the rounded and saturated value of sum over k=0..N-1 of c[k]*x[n-k]. Here c[k] is the coefficient stored at coefficient address k, x[n] is the newest sample, and x[n-k] is the sample accepted k samples earlier.
- R3: A sample is accepted on an edge where `in_valid` is high and `busy` is low. `busy` is high from the following cycle until the cycle in which `out_valid` rises, and is low in that cycle.
- R4: The accumulator restarts from zero for every sample, so an output depends only on the current history and coefficients and never on earlier sums.
- R5: Rounding is half-up. With A the full-precision sum, the result is floor((A + 2^14) / 2^15).
- R6: A rounded result above 32767 is output as 32767 (0x7FFF), and one below -32768 is output as -32768 (0x8000).
- R7: A coefficient write (`coef_we` high) stores `coef_data` at `coef_addr` when `busy` is low. When `busy` is high the write is ignored and the stored coefficient is unchanged.
- R8: When `in_valid` is high while `busy` is high, the sample is dropped and leaves the history unchanged. `overrun` is high for one cycle, one edge later.
- R9: The tap count `taps` is latched when a sample is accepted. Values 1..MAX_TAPS are used as given, 0 acts as 1, and values above MAX_TAPS act as MAX_TAPS. The history pointer wraps at the latched count.
- R10: While reset is high and after it, until the first sample, `out_valid`, `busy` and `overrun` are low and `out_data` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample strobe |
| in_data | input | DATA_W | Signed input sample |
| taps | input | $clog2(MAX_TAPS+1) | Active tap count |
| coef_we | input | 1 | Coefficient write enable |
| coef_addr | input | $clog2(MAX_TAPS) | Coefficient index |
| coef_data | input | DATA_W | Signed coefficient |
| busy | output | 1 | Computation in progress |
| overrun | output | 1 | Sample dropped because busy |
| out_valid | output | 1 | Output strobe |
| out_data | output | DATA_W | Rounded, saturated output sample |

## Verification
The bench builds the filter with MAX_TAPS=8 and GUARD_W=8. With this depth, pointer wrap happens every few samples, and a full table of eight extreme products drives the sum far past the 16-bit range in both directions. At run time it uses tap counts of 1, 5 and 8. The single-tap case isolates the rounding boundaries at exactly half an output step. The five-tap case leaves unused coefficient entries that must not contribute. The eight-tap case fills the whole memory.

// File: rtl/fir_pkg.sv
package fir_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_TAIL = 2'd2,
    ST_FIN  = 2'd3
  } seq_state_t;
endpackage

// File: rtl/fir_dp_ram.sv
// Simple dual-port memory: one write port, one registered read port.
module fir_dp_ram #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 32,
  parameter int AW    = 5
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/fir_seq.sv
// Sequencer: history write pointer, operand address walk, issue tags.
module fir_seq
  import fir_pkg::*;
#(
  parameter int MAX_TAPS = 32,
  parameter int AW       = 5,
  parameter int CW       = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [CW-1:0] taps,
  output logic          busy,
  output logic          overrun,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic          rd_en,
  output logic [AW-1:0] smp_addr,
  output logic [AW-1:0] cf_addr,
  output logic          iss_valid,
  output logic          iss_first,
  output logic          iss_last
);
  localparam logic [CW-1:0] NMAX = CW'(MAX_TAPS);
  localparam logic [CW-1:0] ONE  = CW'(1);

  seq_state_t    st;
  logic [CW-1:0] n_q, n_new, wr_ptr, wr_next, smp_ptr, cf_ptr, cnt;
  logic          accept;

  always_comb begin
    if (taps == '0)       n_new = ONE;
    else if (taps > NMAX) n_new = NMAX;
    else                  n_new = taps;
  end

  always_comb wr_next = (wr_ptr >= n_new - ONE) ? '0 : wr_ptr + ONE;

  assign accept   = in_valid && (st == ST_IDLE);
  assign wr_en    = accept;
  assign wr_addr  = wr_ptr[AW-1:0];
  assign rd_en    = (st == ST_RUN);
  assign smp_addr = smp_ptr[AW-1:0];
  assign cf_addr  = cf_ptr[AW-1:0];
  assign busy     = (st != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      n_q       <= ONE;
      wr_ptr    <= '0;
      smp_ptr   <= '0;
      cf_ptr    <= '0;
      cnt       <= '0;
      overrun   <= 1'b0;
      iss_valid <= 1'b0;
      iss_first <= 1'b0;
      iss_last  <= 1'b0;
    end else begin
      overrun   <= in_valid && (st != ST_IDLE);
      iss_valid <= (st == ST_RUN);
      iss_first <= (st == ST_RUN) && (cnt == '0);
      iss_last  <= (st == ST_RUN) && (cnt == n_q - ONE);
      unique case (st)
        ST_IDLE: if (accept) begin
          n_q     <= n_new;
          wr_ptr  <= wr_next;
          smp_ptr <= wr_next;          // oldest sample sits just past the newest
          cf_ptr  <= n_new - ONE;      // coefficient walk starts at the table end
          cnt     <= '0;
          st      <= ST_RUN;
        end
        ST_RUN: begin
          smp_ptr <= (smp_ptr >= n_q - ONE) ? '0 : smp_ptr + ONE;
          cf_ptr  <= cf_ptr - ONE;
          cnt     <= cnt + ONE;
          if (cnt == n_q - ONE) st <= ST_TAIL;
        end
        ST_TAIL: st <= ST_FIN;
        ST_FIN:  st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assert_ptr_range_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_ptr < n_q) && (n_q != '0) && (n_q <= NMAX));

  assert_accept_sets_busy_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !busy) |=> busy);
endmodule

// File: rtl/fir_mac.sv
// Shared multiply-accumulate with half-up rounding and saturation.
module fir_mac #(
  parameter int DATA_W  = 16,
  parameter int GUARD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              iss_valid,
  input  logic              iss_first,
  input  logic              iss_last,
  input  logic [DATA_W-1:0] smp,
  input  logic [DATA_W-1:0] cf,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);
  localparam int PROD_W = 2 * DATA_W;
  localparam int ACC_W  = PROD_W + GUARD_W;
  localparam int FRAC   = DATA_W - 1;
  localparam logic signed [ACC_W-1:0] RND  = {{(ACC_W-1){1'b0}}, 1'b1} << (FRAC - 1);
  localparam logic signed [ACC_W-1:0] PMAX = {{(ACC_W-FRAC){1'b0}}, {FRAC{1'b1}}};
  localparam logic signed [ACC_W-1:0] NMIN = {{(ACC_W-FRAC){1'b1}}, {FRAC{1'b0}}};

  logic signed [PROD_W-1:0] prod;
  logic signed [ACC_W-1:0]  acc, acc_base, rnd_sum, scaled;
  logic                     last_q;
  logic [DATA_W-1:0]        result;

  always_comb begin
    prod     = $signed(smp) * $signed(cf);
    acc_base = iss_first ? '0 : acc;
    rnd_sum  = acc + RND;
    scaled   = rnd_sum >>> FRAC;
    if (scaled > PMAX)      result = PMAX[DATA_W-1:0];
    else if (scaled < NMIN) result = NMIN[DATA_W-1:0];
    else                    result = scaled[DATA_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc       <= '0;
      last_q    <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      if (iss_valid) acc <= acc_base + ACC_W'(prod);
      last_q    <= iss_valid && iss_last;
      out_valid <= last_q;
      if (last_q) out_data <= result;
    end
  end

  assert_single_pulse_R1: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  assert_first_is_issue_R4: assert property (@(posedge clk) disable iff (rst)
    (iss_first || iss_last) |-> iss_valid);
endmodule

// File: rtl/seq_fir.sv
module seq_fir #(
  parameter int DATA_W   = 16,
  parameter int MAX_TAPS = 32,
  parameter int GUARD_W  = 8,
  localparam int AW = (MAX_TAPS > 1) ? $clog2(MAX_TAPS) : 1,
  localparam int CW = $clog2(MAX_TAPS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic [CW-1:0]     taps,
  input  logic              coef_we,
  input  logic [AW-1:0]     coef_addr,
  input  logic [DATA_W-1:0] coef_data,
  output logic              busy,
  output logic              overrun,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);
  logic              wr_en, rd_en, iss_valid, iss_first, iss_last, cf_we;
  logic [AW-1:0]     wr_addr, smp_addr, cf_addr;
  logic [DATA_W-1:0] smp_q, cf_q;

  assign cf_we = coef_we && !busy;

  fir_seq #(.MAX_TAPS(MAX_TAPS), .AW(AW), .CW(CW)) u_seq (
    .clk(clk), .rst(rst), .in_valid(in_valid), .taps(taps),
    .busy(busy), .overrun(overrun),
    .wr_en(wr_en), .wr_addr(wr_addr), .rd_en(rd_en),
    .smp_addr(smp_addr), .cf_addr(cf_addr),
    .iss_valid(iss_valid), .iss_first(iss_first), .iss_last(iss_last)
  );

  fir_dp_ram #(.WIDTH(DATA_W), .DEPTH(MAX_TAPS), .AW(AW)) u_hist (
    .clk(clk), .we(wr_en), .waddr(wr_addr), .wdata(in_data),
    .re(rd_en), .raddr(smp_addr), .rdata(smp_q)
  );

  fir_dp_ram #(.WIDTH(DATA_W), .DEPTH(MAX_TAPS), .AW(AW)) u_coef (
    .clk(clk), .we(cf_we), .waddr(coef_addr), .wdata(coef_data),
    .re(rd_en), .raddr(cf_addr), .rdata(cf_q)
  );

  fir_mac #(.DATA_W(DATA_W), .GUARD_W(GUARD_W)) u_mac (
    .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_first(iss_first),
    .iss_last(iss_last), .smp(smp_q), .cf(cf_q),
    .out_valid(out_valid), .out_data(out_data)
  );

  assert_busy_ends_at_output_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> out_valid);

  assert_overrun_only_when_busy_R8: assert property (@(posedge clk) disable iff (rst)
    overrun |-> $past(busy));
endmodule

// File: tb/seq_fir_test.sv
module seq_fir_test;
  localparam int DW = 16;
  localparam int MT = 8;
  localparam int GW = 8;
  localparam int CW = $clog2(MT + 1);
  localparam int AW = $clog2(MT);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic [CW-1:0] taps = CW'(1);
  logic          coef_we = 1'b0;
  logic [AW-1:0] coef_addr = '0;
  logic [DW-1:0] coef_data = '0;
  logic          busy, overrun, out_valid;
  logic [DW-1:0] out_data;

  always #2 clk = ~clk;

  seq_fir #(.DATA_W(DW), .MAX_TAPS(MT), .GUARD_W(GW)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .taps(taps),
    .coef_we(coef_we), .coef_addr(coef_addr), .coef_data(coef_data),
    .busy(busy), .overrun(overrun), .out_valid(out_valid), .out_data(out_data)
  );

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;
  int ntap = 1;
  int fill = 0;
  logic signed [DW-1:0] hist [MT];
  logic signed [DW-1:0] cmod [MT];

  function automatic int model_out();
    longint s = 0;
    for (int k = 0; k < ntap; k++) s += longint'(cmod[k]) * longint'(hist[k]);
    s = (s + 64'sd16384) >>> 15;
    if (s > 32767) s = 32767;
    if (s < -32768) s = -32768;
    return int'(s);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input int n);
    rst = 1'b1; in_valid = 1'b0; coef_we = 1'b0; taps = CW'(n);
    repeat (3) @(negedge clk);
    check("R10 out_valid in reset", int'(out_valid), 0);
    check("R10 busy in reset", int'(busy), 0);
    check("R10 out_data in reset", int'(out_data), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R10 overrun after reset", int'(overrun), 0);
    ntap = n; fill = 0;
  endtask

  task automatic load_coef(input int a, input logic signed [DW-1:0] v);
    @(negedge clk);
    coef_we = 1'b1; coef_addr = AW'(a); coef_data = v;
    @(negedge clk);
    coef_we = 1'b0;
    cmod[a] = v;
  endtask

  // mode 0: plain; 1: extra strobe while busy; 2: coefficient write while busy
  task automatic push(input logic signed [DW-1:0] x, input int mode, input string tag);
    int lat;
    while (busy) @(negedge clk);
    in_valid = 1'b1; in_data = x;
    @(negedge clk);
    in_valid = 1'b0;
    for (int k = MT - 1; k > 0; k--) hist[k] = hist[k-1];
    hist[0] = x;
    fill++;
    lat = 0;
    check("R3 busy after accept", int'(busy), 1);
    if (mode == 1) begin
      in_valid = 1'b1; in_data = 16'h5A5A;
      @(negedge clk);
      in_valid = 1'b0; lat = 1;
      check("R8 overrun flag", int'(overrun), 1);
    end else if (mode == 2) begin
      coef_we = 1'b1; coef_addr = '0; coef_data = 16'h1234;
      @(negedge clk);
      coef_we = 1'b0; lat = 1;
    end
    while (!out_valid && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    check("R1 latency", lat, ntap + 2);
    check("R3 busy low with output", int'(busy), 0);
    if (fill >= ntap) check(tag, int'($signed(out_data)), model_out());
    @(negedge clk);
    check("R1 single-cycle strobe", int'(out_valid), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    for (int k = 0; k < MT; k++) begin hist[k] = '0; cmod[k] = '0; end

    // Single tap: rounding boundaries (R5, R9)
    do_reset(1);
    load_coef(0, 16'sd1);
    push(16'sd16384, 0, "R5 +half rounds up");
    push(16'sd16383, 0, "R5 below half");
    push(-16'sd16384, 0, "R5 -half rounds up to zero");
    push(-16'sd16385, 0, "R5 below -half");
    push(16'sd32767, 0, "R9 single tap");

    // Eight taps, extremes: saturation (R6)
    do_reset(8);
    for (int k = 0; k < MT; k++) load_coef(k, 16'sh7FFF);
    for (int i = 0; i < 8; i++) push(16'sh7FFF, 0, "R6 positive saturation");
    check("R6 positive clamp value", int'($signed(out_data)), 32767);
    for (int i = 0; i < 8; i++) push(16'sh8000, 0, "R6 negative saturation");
    check("R6 negative clamp value", int'($signed(out_data)), -32768);

    // Five taps, random: convolution, overrun, busy coefficient write
    do_reset(5);
    for (int k = 0; k < MT; k++) load_coef(k, DW'($signed(12'($urandom()))));
    for (int i = 0; i < 30; i++) begin
      logic signed [DW-1:0] r = DW'($urandom());
      if (i == 12)      push(r, 1, "R8 output with dropped strobe");
      else if (i == 13) push(r, 0, "R8 history unchanged by dropped sample");
      else if (i == 20) push(r, 2, "R7 busy write ignored");
      else if (i == 21) push(r, 0, "R7 coefficient still old");
      else              push(r, 0, "R2 five-tap convolution");
    end
    for (int i = 0; i < 5; i++) push('0, 0, "R4 accumulator restarts");
    check("R4 zero history gives zero", int'($signed(out_data)), 0);

    // Eight taps, full-range random (R2, R6)
    do_reset(8);
    for (int k = 0; k < MT; k++) load_coef(k, DW'($urandom()));
    for (int i = 0; i < 40; i++) push(DW'($urandom()), 0, "R2 eight-tap full range");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule